// File: doc/BRIEF.md
# Sensor-Actuated Two-Road Intersection Light Controller

This block sequences the lamps at a crossing of a priority road ("main") and a minor road ("side"). Each road has a red, a yellow and a green lamp and a vehicle-presence sensor. A one-clock pulse, `tick`, arrives once per second. The block advances its phase timer only on that pulse. All other logic runs on the system clock.

The main road keeps green until a side-road vehicle is detected. When both roads have traffic, the two roads take turns: the main road gets 45 s of green and the side road gets 25 s. A 5 s yellow separates every green from the following red. If a road's green is no longer needed, it ends early. That happens when the main road is empty while the side road waits, or when the side road empties during its own green.

For each road the block also gives a two-digit countdown as packed BCD, ready for an external display decoder. This is the seconds left until that road's lamp next changes colour. For the road held at red, the count includes the other road's yellow.

Top module: `xing_light_ctrl`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a clock edge) puts the block in main green / side red with the phase timer cleared, so the counts read main 8'h45 and side 8'h50.
- R2: During main green with `side_car` low, the phase stays main green and the timer is held cleared, whatever `tick` and `main_car` do.
- R3: During main green with both sensors high, the 45th `tick` moves the phase to main yellow; after 44 ticks it is still main green.
- R4: During main green, `side_car` high with `main_car` low moves the phase to main yellow at the next clock edge, with no `tick` needed.
- R5: Each yellow phase ends on its 5th `tick`: main yellow goes to side green and side yellow goes to main green.
- R6: During side green with both sensors high, the 25th `tick` moves the phase to side yellow.
- R7: During side green, `side_car` low moves the phase to side yellow at the next clock edge, with no `tick` needed.
- R8: During side green with `side_car` high and `main_car` low, the phase stays side green and the timer is held cleared.
- R9: Each lamp vector is {red, yellow, green} in bits [2:1:0]. Exactly one lamp per road is lit, and at least one road always shows red.
- R10: Counts are packed BCD, with tens in bits [7:4] and units in bits [3:0]. With t the number of ticks counted in the current phase, the counts are:
  - main green: main 45−t, side 50−t
  - main yellow: both 5−t
  - side green: main 30−t, side 25−t
  - side yellow: both 5−t
- R11: The phase timer advances only on a clock edge where `tick` is high. Every phase change restarts it at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | One-clock pulse per second |
| main_car | input | 1 | Vehicle present on the main road |
| side_car | input | 1 | Vehicle present on the side road |
| main_lamps | output | 3 | Main road lamps {red, yellow, green} |
| side_lamps | output | 3 | Side road lamps {red, yellow, green} |
| main_count | output | 8 | Main road seconds left, packed BCD |
| side_count | output | 8 | Side road seconds left, packed BCD |

## Verification
Directed runs walk a full cycle with both sensors held high, counting exact ticks. This shows the 45/5/25/5 durations and the count values at each phase boundary. They are the only way to tell an off-by-one timer from a correct one. Further directed cases apply one sensor pattern at a time: side-only during main green, main-only during side green, and side dropping during side green. These separate the early exits (no tick needed) from the hold-and-clear behaviour. Cycles without a tick show that the timer waits for the pulse. A long random run then varies the tick rate and toggles the sensors at random. It compares lamps and counts every cycle against a bench model, which checks sensor changes in the middle of a phase.

// File: rtl/xing_pkg.sv
// Shared types for the intersection light controller.
// Assumes: the four phases form a fixed ring in the order listed.
package xing_pkg;
    typedef enum logic [1:0] {
        PH_MAIN_GO    = 2'd0,
        PH_MAIN_AMBER = 2'd1,
        PH_SIDE_GO    = 2'd2,
        PH_SIDE_AMBER = 2'd3
    } phase_t;

    // Lamp vector layout {red, yellow, green}
    localparam logic [2:0] LAMP_RED    = 3'b100;
    localparam logic [2:0] LAMP_YELLOW = 3'b010;
    localparam logic [2:0] LAMP_GREEN  = 3'b001;
endpackage

// File: rtl/xing_phase_ctrl.sv
// Phase sequencer with its elapsed-seconds timer.
// Does: walks main green -> main yellow -> side green -> side yellow,
//       with sensor-driven holds and early exits on the green phases.
// Assumes: tick is a single-cycle pulse; TW is wide enough for the
//          longest phase duration.
module xing_phase_ctrl
    import xing_pkg::*;
#(
    parameter int MAIN_GO_S = 45,
    parameter int SIDE_GO_S = 25,
    parameter int AMBER_S   = 5,
    parameter int TW        = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          main_car,
    input  logic          side_car,
    output phase_t        phase_o,
    output logic [TW-1:0] elapsed_o
);
    localparam logic [TW-1:0] MAIN_LAST  = TW'(MAIN_GO_S - 1);
    localparam logic [TW-1:0] SIDE_LAST  = TW'(SIDE_GO_S - 1);
    localparam logic [TW-1:0] AMBER_LAST = TW'(AMBER_S - 1);

    phase_t        phase_q, phase_d;
    logic [TW-1:0] elapsed_q, elapsed_d;
    logic [TW-1:0] last_sec;
    phase_t        next_in_ring;

    // Pick the final timer value and the successor for the current phase
    always_comb begin
        case (phase_q)
            PH_MAIN_GO:    begin last_sec = MAIN_LAST;  next_in_ring = PH_MAIN_AMBER; end
            PH_MAIN_AMBER: begin last_sec = AMBER_LAST; next_in_ring = PH_SIDE_GO;    end
            PH_SIDE_GO:    begin last_sec = SIDE_LAST;  next_in_ring = PH_SIDE_AMBER; end
            default:       begin last_sec = AMBER_LAST; next_in_ring = PH_MAIN_GO;    end
        endcase
    end

    // Next-state logic: sensor holds, early exits and tick-driven expiry
    always_comb begin
        phase_d   = phase_q;
        elapsed_d = elapsed_q;
        case (phase_q)
            PH_MAIN_GO: begin
                if (!side_car) begin
                    elapsed_d = '0;
                end else if (!main_car) begin
                    phase_d   = PH_MAIN_AMBER;
                    elapsed_d = '0;
                end else if (tick) begin
                    if (elapsed_q == last_sec) begin
                        phase_d   = next_in_ring;
                        elapsed_d = '0;
                    end else begin
                        elapsed_d = elapsed_q + 1'b1;
                    end
                end
            end
            PH_SIDE_GO: begin
                if (!side_car) begin
                    phase_d   = PH_SIDE_AMBER;
                    elapsed_d = '0;
                end else if (!main_car) begin
                    elapsed_d = '0;
                end else if (tick) begin
                    if (elapsed_q == last_sec) begin
                        phase_d   = next_in_ring;
                        elapsed_d = '0;
                    end else begin
                        elapsed_d = elapsed_q + 1'b1;
                    end
                end
            end
            default: begin
                if (tick) begin
                    if (elapsed_q == last_sec) begin
                        phase_d   = next_in_ring;
                        elapsed_d = '0;
                    end else begin
                        elapsed_d = elapsed_q + 1'b1;
                    end
                end
            end
        endcase
    end

    // State registers with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_MAIN_GO;
            elapsed_q <= '0;
        end else begin
            phase_q   <= phase_d;
            elapsed_q <= elapsed_d;
        end
    end

    assign phase_o   = phase_q;
    assign elapsed_o = elapsed_q;

    // R11: without a tick the timer either holds or restarts from zero
    p_timer_waits_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> (elapsed_q == $past(elapsed_q) || elapsed_q == '0));

    // R11: a phase change always restarts the timer
    p_timer_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != $past(phase_q)) |-> (elapsed_q == '0));

    // R5: a yellow phase is left only on a tick
    p_amber_needs_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_MAIN_AMBER || phase_q == PH_SIDE_AMBER) && !tick
        |=> $stable(phase_q));
endmodule

// File: rtl/xing_countdown.sv
// Seconds-left calculation for both roads.
// Does: subtracts the phase timer from each road's time to its next
//       lamp change; a road at red also waits out the other's yellow.
// Assumes: elapsed never exceeds the current phase duration.
module xing_countdown
    import xing_pkg::*;
#(
    parameter int MAIN_GO_S = 45,
    parameter int SIDE_GO_S = 25,
    parameter int AMBER_S   = 5,
    parameter int TW        = 6
) (
    input  phase_t        phase_i,
    input  logic [TW-1:0] elapsed_i,
    output logic [TW-1:0] main_left,
    output logic [TW-1:0] side_left
);
    localparam logic [TW-1:0] MAIN_GO_T   = TW'(MAIN_GO_S);
    localparam logic [TW-1:0] SIDE_GO_T   = TW'(SIDE_GO_S);
    localparam logic [TW-1:0] AMBER_T     = TW'(AMBER_S);
    localparam logic [TW-1:0] MAIN_WAIT_T = TW'(SIDE_GO_S + AMBER_S);
    localparam logic [TW-1:0] SIDE_WAIT_T = TW'(MAIN_GO_S + AMBER_S);

    // Per-phase starting values minus elapsed seconds
    always_comb begin
        case (phase_i)
            PH_MAIN_GO: begin
                main_left = MAIN_GO_T - elapsed_i;
                side_left = SIDE_WAIT_T - elapsed_i;
            end
            PH_SIDE_GO: begin
                main_left = MAIN_WAIT_T - elapsed_i;
                side_left = SIDE_GO_T - elapsed_i;
            end
            default: begin
                main_left = AMBER_T - elapsed_i;
                side_left = AMBER_T - elapsed_i;
            end
        endcase
    end
endmodule

// File: rtl/xing_bcd2.sv
// Two-digit binary to packed BCD converter.
// Does: splits a value below 100 into tens (upper nibble) and units.
// Assumes: the input is less than 100.
module xing_bcd2 #(
    parameter int W = 6
) (
    input  logic [W-1:0] bin,
    output logic [7:0]   bcd
);
    // Divide by ten for the tens digit, remainder for the units
    always_comb begin
        bcd = {4'(bin / W'(10)), 4'(bin % W'(10))};
    end
endmodule

// File: rtl/xing_light_ctrl.sv
// Top of the intersection light controller.
// Does: drives both roads' lamps and BCD countdowns from the phase
//       sequencer.
// Assumes: tick is a one-cycle pulse once per second; sensors are
//          already synchronised and debounced.
module xing_light_ctrl
    import xing_pkg::*;
#(
    parameter int MAIN_GO_S = 45,
    parameter int SIDE_GO_S = 25,
    parameter int AMBER_S   = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       main_car,
    input  logic       side_car,
    output logic [2:0] main_lamps,
    output logic [2:0] side_lamps,
    output logic [7:0] main_count,
    output logic [7:0] side_count
);
    localparam int LONGEST = (MAIN_GO_S > SIDE_GO_S ? MAIN_GO_S : SIDE_GO_S) + AMBER_S;
    localparam int TW      = $clog2(LONGEST + 1);
    localparam int ROADS   = 2;

    phase_t                    phase;
    logic [TW-1:0]             elapsed;
    logic [ROADS-1:0][TW-1:0]  left_bin;
    logic [ROADS-1:0][7:0]     left_bcd;

    xing_phase_ctrl #(
        .MAIN_GO_S(MAIN_GO_S), .SIDE_GO_S(SIDE_GO_S), .AMBER_S(AMBER_S), .TW(TW)
    ) u_phase (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .main_car(main_car), .side_car(side_car),
        .phase_o(phase), .elapsed_o(elapsed)
    );

    xing_countdown #(
        .MAIN_GO_S(MAIN_GO_S), .SIDE_GO_S(SIDE_GO_S), .AMBER_S(AMBER_S), .TW(TW)
    ) u_count (
        .phase_i(phase), .elapsed_i(elapsed),
        .main_left(left_bin[0]), .side_left(left_bin[1])
    );

    // One BCD converter per road
    for (genvar r = 0; r < ROADS; r++) begin : g_road_bcd
        xing_bcd2 #(.W(TW)) u_bcd (.bin(left_bin[r]), .bcd(left_bcd[r]));
    end

    assign main_count = left_bcd[0];
    assign side_count = left_bcd[1];

    // Lamp decode from the current phase
    always_comb begin
        case (phase)
            PH_MAIN_GO:    begin main_lamps = LAMP_GREEN;  side_lamps = LAMP_RED;    end
            PH_MAIN_AMBER: begin main_lamps = LAMP_YELLOW; side_lamps = LAMP_RED;    end
            PH_SIDE_GO:    begin main_lamps = LAMP_RED;    side_lamps = LAMP_GREEN;  end
            default:       begin main_lamps = LAMP_RED;    side_lamps = LAMP_YELLOW; end
        endcase
    end

    // R9: one lamp per road
    p_one_lamp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(main_lamps) == 1) && ($countones(side_lamps) == 1));

    // R9: at least one road always at red
    p_one_road_red_r9: assert property (@(posedge clk) disable iff (!rst_n)
        main_lamps[2] || side_lamps[2]);

    // R2: main green rests while no side vehicle is present
    p_main_rest_r2: assert property (@(posedge clk) disable iff (!rst_n)
        main_lamps[0] && !side_car |=> main_lamps[0]);

    // R4: side-only demand ends main green at once
    p_main_early_r4: assert property (@(posedge clk) disable iff (!rst_n)
        main_lamps[0] && side_car && !main_car |=> main_lamps[1]);

    // R7: an empty side road ends side green at once
    p_side_early_r7: assert property (@(posedge clk) disable iff (!rst_n)
        side_lamps[0] && !side_car |=> side_lamps[1]);

    // R10: both BCD digits stay within 0..9
    p_bcd_digits_r10: assert property (@(posedge clk) disable iff (!rst_n)
        main_count[7:4] <= 4'd9 && main_count[3:0] <= 4'd9 &&
        side_count[7:4] <= 4'd9 && side_count[3:0] <= 4'd9);
endmodule

// File: tb/tb_xing_light_ctrl.sv
module tb_xing_light_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       main_car = 1'b0;
    logic       side_car = 1'b0;
    logic [2:0] main_lamps, side_lamps;
    logic [7:0] main_count, side_count;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Bench model: phase 0 main green, 1 main yellow, 2 side green, 3 side yellow
    int m_ph = 0;
    int m_t  = 0;

    always #2 clk = ~clk;

    xing_light_ctrl dut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .main_car(main_car), .side_car(side_car),
        .main_lamps(main_lamps), .side_lamps(side_lamps),
        .main_count(main_count), .side_count(side_count)
    );

    function automatic logic [7:0] to_bcd(int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic int dur_of(int ph);
        case (ph)
            0: return 45;
            2: return 25;
            default: return 5;
        endcase
    endfunction

    function automatic logic [2:0] exp_main_lamps(int ph);
        case (ph)
            0: return 3'b001;
            1: return 3'b010;
            default: return 3'b100;
        endcase
    endfunction

    function automatic logic [2:0] exp_side_lamps(int ph);
        case (ph)
            2: return 3'b001;
            3: return 3'b010;
            default: return 3'b100;
        endcase
    endfunction

    function automatic int exp_main_left(int ph, int t);
        case (ph)
            0: return 45 - t;
            2: return 30 - t;
            default: return 5 - t;
        endcase
    endfunction

    function automatic int exp_side_left(int ph, int t);
        case (ph)
            0: return 50 - t;
            2: return 25 - t;
            default: return 5 - t;
        endcase
    endfunction

    task automatic model_step(bit rs_n, bit tk, bit mc, bit sc);
        if (!rs_n) begin
            m_ph = 0; m_t = 0;
        end else if (m_ph == 0 && !sc) begin
            m_t = 0;
        end else if (m_ph == 0 && !mc) begin
            m_ph = 1; m_t = 0;
        end else if (m_ph == 2 && !sc) begin
            m_ph = 3; m_t = 0;
        end else if (m_ph == 2 && !mc) begin
            m_t = 0;
        end else if (tk) begin
            if (m_t == dur_of(m_ph) - 1) begin
                m_ph = (m_ph + 1) % 4; m_t = 0;
            end else begin
                m_t = m_t + 1;
            end
        end
    endtask

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Compare all outputs against the model
    task automatic chk_model();
        chk("R9 main lamps", {5'd0, main_lamps}, {5'd0, exp_main_lamps(m_ph)});
        chk("R9 side lamps", {5'd0, side_lamps}, {5'd0, exp_side_lamps(m_ph)});
        chk("R10 main count", main_count, to_bcd(exp_main_left(m_ph, m_t)));
        chk("R10 side count", side_count, to_bcd(exp_side_left(m_ph, m_t)));
    endtask

    // Drive one cycle of inputs, update the model at the edge, compare after
    task automatic step(bit rs_n, bit tk, bit mc, bit sc);
        rst_n = rs_n; tick = tk; main_car = mc; side_car = sc;
        @(posedge clk);
        model_step(rs_n, tk, mc, sc);
        @(negedge clk);
        chk_model();
    endtask

    // Several ticks, each followed by one idle cycle
    task automatic ticks(int n, bit mc, bit sc);
        for (int i = 0; i < n; i++) begin
            step(1'b1, 1'b1, mc, sc);
            step(1'b1, 1'b0, mc, sc);
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        @(negedge clk);
        // R1: reset with traffic on both roads
        step(1'b0, 1'b1, 1'b1, 1'b1);
        step(1'b0, 1'b1, 1'b1, 1'b1);
        step(1'b1, 1'b0, 1'b1, 1'b0);
        chk("R1 main lamps", {5'd0, main_lamps}, 8'h01);
        chk("R1 side lamps", {5'd0, side_lamps}, 8'h04);
        chk("R1 main count", main_count, 8'h45);
        chk("R1 side count", side_count, 8'h50);

        // R2: no side traffic, many ticks: main stays green, counts frozen
        ticks(60, 1'b1, 1'b0);
        chk("R2 main lamps", {5'd0, main_lamps}, 8'h01);
        chk("R2 main count", main_count, 8'h45);
        chk("R2 side count", side_count, 8'h50);

        // R3: both sensed, 44 ticks leave main green at its last second
        ticks(44, 1'b1, 1'b1);
        chk("R3 main lamps at 44", {5'd0, main_lamps}, 8'h01);
        chk("R3 main count at 44", main_count, 8'h01);
        chk("R3 side count at 44", side_count, 8'h06);
        // R11: idle cycles without tick do not advance the timer
        step(1'b1, 1'b0, 1'b1, 1'b1);
        step(1'b1, 1'b0, 1'b1, 1'b1);
        chk("R11 main count hold", main_count, 8'h01);
        ticks(1, 1'b1, 1'b1);
        chk("R3 main lamps at 45", {5'd0, main_lamps}, 8'h02);
        chk("R10 yellow main count", main_count, 8'h05);
        chk("R10 yellow side count", side_count, 8'h05);

        // R5: main yellow lasts five ticks
        ticks(4, 1'b1, 1'b1);
        chk("R5 main still yellow", {5'd0, main_lamps}, 8'h02);
        chk("R5 yellow count 1", main_count, 8'h01);
        ticks(1, 1'b1, 1'b1);
        chk("R5 side lamps green", {5'd0, side_lamps}, 8'h01);
        chk("R10 side green side count", side_count, 8'h25);
        chk("R10 side green main count", main_count, 8'h30);

        // R6: side green lasts 25 ticks with both sensed
        ticks(24, 1'b1, 1'b1);
        chk("R6 side still green", {5'd0, side_lamps}, 8'h01);
        chk("R6 side count at 24", side_count, 8'h01);
        chk("R6 main count at 24", main_count, 8'h06);
        ticks(1, 1'b1, 1'b1);
        chk("R6 side yellow", {5'd0, side_lamps}, 8'h02);

        // R5: side yellow returns to main green after five ticks
        ticks(5, 1'b1, 1'b1);
        chk("R5 back to main green", {5'd0, main_lamps}, 8'h01);
        chk("R5 main count restarts", main_count, 8'h45);

        // R4: side only, no tick: main yellow next edge
        step(1'b1, 1'b0, 1'b0, 1'b1);
        chk("R4 early main yellow", {5'd0, main_lamps}, 8'h02);
        ticks(5, 1'b0, 1'b1);
        chk("R8 side green entered", {5'd0, side_lamps}, 8'h01);

        // R8: side present, main absent: side green holds, counts frozen
        ticks(40, 1'b0, 1'b1);
        chk("R8 side still green", {5'd0, side_lamps}, 8'h01);
        chk("R8 side count frozen", side_count, 8'h25);
        chk("R8 main count frozen", main_count, 8'h30);

        // R7: side empties, no tick: side yellow next edge
        step(1'b1, 1'b0, 1'b0, 1'b0);
        chk("R7 early side yellow", {5'd0, side_lamps}, 8'h02);
        chk("R7 side count", side_count, 8'h05);

        // Random traffic and tick pattern, compared each cycle
        begin
            bit mc = 1'b1;
            bit sc = 1'b1;
            for (int i = 0; i < 4000; i++) begin
                if ($urandom_range(0, 39) == 0) mc = ~mc;
                if ($urandom_range(0, 29) == 0) sc = ~sc;
                step(($urandom_range(0, 999) != 0), ($urandom_range(0, 2) == 0), mc, sc);
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule